// File: doc/BRIEF.md
# Tick Timer with Match Modes

A processor tick timer built from two registers: a free-running count register and a control register. The control register holds an operating mode, an interrupt enable, an interrupt-pending flag and a match period. Both registers can be written and read through a simple one-cycle register port. When the timer is enabled, the count advances by one on every cycle in which the tick enable input is high. On each of those ticks the low bits of the count are compared with the programmed period.

On a match the timer can latch an interrupt-pending flag, which drives a level interrupt output. The mode field decides what the count does next. In restart mode it returns to zero. In one-shot mode it stops until software writes a register again. In continuous mode it keeps counting and wraps past the top of its range. Software clears a pending interrupt by writing the control register with a 0 in the pending position. Writing a 1 in that position leaves the flag as it was, so unrelated fields can be updated without losing an interrupt.

Top module: `tick_timer`

## Requirements
- R1: After reset the count register, the control register and irqOut are all zero.
- R2: The control register layout is mode in bits 31:30 (00 off, 01 restart, 10 one-shot, 11 continuous), interrupt enable in bit 29, pending in bit 28 and period in bits 27:0. rdData returns the live count when rdSel=0 and the live control register when rdSel=1.
- R3: In mode 00 the count never advances.
- R4: A match happens on a tick in which the timer is running and count bits 27:0 equal the period. Count bits 31:28 are ignored.
- R5: A match sets the pending bit only when interrupt enable is 1. irqOut always equals the pending bit.
- R6: In restart mode, a match loads the count with zero.
- R7: In one-shot mode, a match holds the count at its value and stops counting. A later write to either register restarts counting if the mode is nonzero.
- R8: In continuous mode, a match does not disturb the count, which keeps incrementing.
- R9: A control write with bit 28 = 1 keeps the current pending value. A control write with bit 28 = 0 clears pending and drops irqOut on the next cycle.
- R10: A count write (wrEn=1, wrSel=0) loads wrData at any time. With a nonzero mode, counting then continues from the loaded value.
- R11: The count advances by exactly one per cycle with tickEn=1 and holds when tickEn=0. It wraps from 0xFFFFFFFF to 0.
- R12: When a write and a match land in the same cycle, the written register takes the written value, and the match's update to that register is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable tick |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 count, 1 control |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read select: 0 count, 1 control |
| rdData | output | 32 | Read data |
| irqOut | output | 1 | Level interrupt (pending bit) |

## Verification
Directed sequences exercise each mode in turn with small periods. Because the period is small, the matches fall within a few ticks, so the restart-to-zero, the one-shot halt and the continuous pass-through can each be told apart by the count value after the match. Upper count bits that differ from zero separate a low-bit comparison from a full-width one. A match with interrupt enable cleared separates enable gating from an unconditional pending set. A count write placed on the exact match tick exposes which update wins. A long random phase mixes writes of every mode, pending-bit value and small period with sparse tick patterns, and compares both registers and the interrupt every cycle against a bench model.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tick_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntLoad;
    logic cntClr;
    logic cntInc;
    logic ctlLoad;
    logic pendSet;
  } tick_strb_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [1:0]          wrMode,
  input  logic [1:0]          curMode,
  input  logic                curIe,
  input  logic [PERIOD_W-1:0] period,
  input  logic [PERIOD_W-1:0] cntLow,
  output tick_strb_t          strb,
  output logic                matchEv
);
  logic       runQ;
  logic       active;
  logic       cntWr;
  logic       ctlWr;
  tick_mode_e mode;

  assign mode    = tick_mode_e'(curMode);
  assign cntWr   = wrEn && !wrSel;
  assign ctlWr   = wrEn && wrSel;
  assign active  = tickEn && runQ && (mode != MODE_OFF);
  assign matchEv = active && (cntLow == period);

  always_comb begin
    strb.cntLoad = cntWr;
    strb.ctlLoad = ctlWr;
    strb.cntClr  = matchEv && (mode == MODE_RESTART) && !cntWr;
    strb.cntInc  = active && !cntWr &&
                   !(matchEv && (mode != MODE_CONT));
    strb.pendSet = matchEv && curIe && !ctlWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (ctlWr) begin
      runQ <= (wrMode != 2'b00);
    end else if (cntWr) begin
      runQ <= (mode != MODE_OFF);
    end else if (matchEv && mode == MODE_ONESHOT) begin
      runQ <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tick_strb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] modeQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int PERIOD_W = DATA_W - 4;
  localparam int IP_BIT   = PERIOD_W;

  logic [DATA_W-1:0] ctlNext;

  always_comb begin
    ctlNext = modeQ;
    if (strb.ctlLoad) begin
      ctlNext         = wrData;
      ctlNext[IP_BIT] = wrData[IP_BIT] & modeQ[IP_BIT];
    end else if (strb.pendSet) begin
      ctlNext[IP_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      modeQ <= '0;
    end else begin
      modeQ <= ctlNext;
      if (strb.cntLoad)     cntQ <= wrData;
      else if (strb.cntClr) cntQ <= '0;
      else if (strb.cntInc) cntQ <= cntQ + 1'b1;
    end
  end

  assign rdData = rdSel ? modeQ : cntQ;
  assign irqOut = modeQ[IP_BIT];
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int PERIOD_W = DATA_W - 4;
  localparam int IE_BIT   = PERIOD_W + 1;
  localparam int MODE_LO  = PERIOD_W + 2;

  tick_strb_t        strb;
  logic              matchEv;
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] modeQ;

  tick_ctrl #(.PERIOD_W(PERIOD_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrMode  (wrData[DATA_W-1:MODE_LO]),
    .curMode (modeQ[DATA_W-1:MODE_LO]),
    .curIe   (modeQ[IE_BIT]),
    .period  (modeQ[PERIOD_W-1:0]),
    .cntLow  (cntQ[PERIOD_W-1:0]),
    .strb    (strb),
    .matchEv (matchEv)
  );

  tick_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdSel  (rdSel),
    .cntQ   (cntQ),
    .modeQ  (modeQ),
    .rdData (rdData),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic              wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] cntQ,
  input logic [DATA_W-1:0] modeQ,
  input logic              irqOut,
  input logic              matchEv
);
  localparam int PERIOD_W = DATA_W - 4;
  localparam int IP_BIT   = PERIOD_W;
  localparam int IE_BIT   = PERIOD_W + 1;
  localparam int MODE_LO  = PERIOD_W + 2;

  logic cntWr;
  assign cntWr = wrEn && !wrSel;

  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[DATA_W-1:MODE_LO] == 2'b00 && !cntWr) |=> $stable(cntQ));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWr) |=> $stable(cntQ));

  // R5
  pend_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(matchEv && modeQ[IE_BIT]));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchEv && modeQ[DATA_W-1:MODE_LO] == 2'b01 && !wrEn) |=> (cntQ == '0));

  // R7
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchEv && modeQ[DATA_W-1:MODE_LO] == 2'b10 && !wrEn) |=> $stable(cntQ));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && !wrData[IP_BIT]) |=> !irqOut);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .cntQ    (cntQ),
  .modeQ   (modeQ),
  .irqOut  (irqOut),
  .matchEv (matchEv)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/100ps
module tick_timer_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tickEn = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdSel = 1'b0;
  logic [W-1:0] rdData;
  logic         irqOut;

  int nChk = 0;
  int nBad = 0;

  logic [W-1:0] mCnt, mCtl;
  logic         mRun;

  always #2 clk = ~clk;

  tick_timer #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic expectEq(input string tag, input logic [W-1:0] act,
                          input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference next-state per the requirements
  task automatic modelStep(input logic we, input logic ws,
                           input logic [W-1:0] wd, input logic tk);
    logic [1:0]   md;
    logic         mt;
    logic [W-1:0] nC, nT;
    logic         nR;
    md = mCtl[31:30];
    nC = mCnt; nT = mCtl; nR = mRun;
    mt = tk && mRun && md != 2'b00 && mCnt[27:0] == mCtl[27:0];
    if (tk && mRun && md != 2'b00) begin
      if (!mt || md == 2'b11) nC = mCnt + 1;
      else if (md == 2'b01)   nC = '0;
      else                    nR = 1'b0;
    end
    if (mt && mCtl[29]) nT[28] = 1'b1;
    if (we && !ws) begin nC = wd; nR = (md != 2'b00); end
    if (we && ws) begin
      nT = wd; nT[28] = wd[28] & mCtl[28]; nR = (wd[31:30] != 2'b00);
    end
    mCnt = nC; mCtl = nT; mRun = nR;
  endtask

  task automatic cyc(input logic we, input logic ws, input logic [W-1:0] wd,
                     input logic tk, input string tag);
    @(negedge clk);
    wrEn = we; wrSel = ws; wrData = wd; tickEn = tk;
    @(posedge clk);
    modelStep(we, ws, wd, tk);
    #0.5;
    wrEn = 1'b0; tickEn = 1'b0;
    rdSel = 1'b0; #0.2;
    expectEq({tag, " count"}, rdData, mCnt);
    rdSel = 1'b1; #0.2;
    expectEq({tag, " ctrl"}, rdData, mCtl);
    expectEq({tag, " irq"}, {31'b0, irqOut}, {31'b0, mCtl[28]});
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b1, tag);
  endtask

  task automatic peek(input string tag, input logic [W-1:0] eCnt, input logic eIrq);
    @(negedge clk);
    rdSel = 1'b0; #0.2;
    expectEq({tag, " direct count"}, rdData, eCnt);
    expectEq({tag, " direct irq"}, {31'b0, irqOut}, {31'b0, eIrq});
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mCnt = '0; mCtl = '0; mRun = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rdSel = 1'b1; #0.2;
    expectEq("R1 ctrl", rdData, '0);
    peek("R1", 32'h0, 1'b0);

    // R3 disabled: ticks do nothing; R10 load while off
    ticks(3, "R3");
    cyc(1'b1, 1'b0, 32'd7, 1'b0, "R10");
    ticks(3, "R3");
    peek("R3", 32'd7, 1'b0);

    // R6 restart with IE, period 3
    cyc(1'b1, 1'b0, 32'd0, 1'b0, "R10");
    cyc(1'b1, 1'b1, 32'h6000_0003, 1'b0, "R2");
    ticks(4, "R6");
    peek("R6", 32'd0, 1'b1);

    // R9 keep then clear
    cyc(1'b1, 1'b1, 32'h7000_0003, 1'b0, "R9");
    peek("R9 keep", 32'd0, 1'b1);
    cyc(1'b1, 1'b1, 32'h6000_0003, 1'b0, "R9");
    peek("R9 clear", 32'd0, 1'b0);

    // R7 one-shot, period 2
    cyc(1'b1, 1'b1, 32'hA000_0002, 1'b0, "R7");
    cyc(1'b1, 1'b0, 32'd0, 1'b0, "R10");
    ticks(5, "R7");
    peek("R7", 32'd2, 1'b1);
    cyc(1'b1, 1'b0, 32'd0, 1'b0, "R7 rearm");
    ticks(1, "R7 rearm");
    peek("R7 rearm", 32'd1, 1'b1);

    // R8 continuous, period 1
    cyc(1'b1, 1'b1, 32'hE000_0001, 1'b0, "R8");
    cyc(1'b1, 1'b0, 32'd0, 1'b0, "R10");
    ticks(3, "R8");
    peek("R8", 32'd3, 1'b1);

    // R11 hold without tick
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0, 1'b0, "R11");
    peek("R11 hold", 32'd3, 1'b1);

    // R4 upper bits ignored; R5 no pending with IE=0
    cyc(1'b1, 1'b1, 32'h4000_0003, 1'b0, "R5");
    cyc(1'b1, 1'b0, 32'hF000_0003, 1'b0, "R4");
    ticks(1, "R4");
    peek("R4 R5", 32'd0, 1'b0);

    // R11 wrap
    cyc(1'b1, 1'b1, 32'hC000_0100, 1'b0, "R11");
    cyc(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, "R11");
    ticks(1, "R11 wrap");
    peek("R11 wrap", 32'd0, 1'b0);

    // R12 count write wins over restart on match tick
    cyc(1'b1, 1'b1, 32'h6000_0005, 1'b0, "R12");
    cyc(1'b1, 1'b0, 32'd5, 1'b0, "R12");
    cyc(1'b1, 1'b0, 32'd9, 1'b1, "R12");
    peek("R12", 32'd9, 1'b1);

    // Random phase: all requirements against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [W-1:0] d;
      r = $urandom_range(0, 15);
      if (r == 0) begin
        d = {$urandom_range(0,3) == 0 ? 4'h0 : 4'(($urandom & 3) << 2 | 4'h0), 28'h0};
        d[31:28] = 4'($urandom_range(0, 15));
        d[27:0]  = 28'($urandom_range(0, 12));
        cyc(1'b1, 1'b1, d, 1'($urandom_range(0, 1)), "R2 R9 R12 random");
      end else if (r == 1) begin
        d = 32'($urandom_range(0, 14));
        if ($urandom_range(0, 7) == 0) d = d | 32'hFFFF_FFF0;
        cyc(1'b1, 1'b0, d, 1'($urandom_range(0, 1)), "R10 R12 random");
      end else begin
        cyc(1'b0, 1'b0, '0, ($urandom_range(0, 3) != 0), "R4 R6 R7 R8 R11 random");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule